// File: doc/BRIEF.md
# Power-Management Event Interrupt Hub

This block gathers thirty-two wake and system event inputs into sticky status bits. It drives three interrupt levels from them: a general interrupt request (IRQ), a system-management interrupt (SMI) and an ACPI-style power-management interrupt (SCI). Software reads and writes the block's registers through a simple single-cycle register port. It acknowledges an event by writing a one to the bit's position.

Only the upper sixteen events can reach IRQ and SMI. Parameters pick which of those sixteen each output may use. All thirty-two events can reach SCI through a separate set of enables. Three special events (power button, sleep button, real-time clock) have a second status/enable pair, so that dual control works. A configuration bit can force each pair to zero.

Software writes a sleep-type field. While the field shows a sleep state, the power-button pair can raise SCI without its enable. An SCI raised during sleep also records a wake flag. Neither of these applies while the external-state-select bit is set.

Top module: `pm_event_irq_hub`

## Requirements
- R1: After reset, every register reads 0 and irq_o, smi_o and sci_o are 0. The sleep type is 0, which means the awake state.
- R2: A high ev_in[k] sets status bit k. Status bit k sits at address k/8, bit k%8. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear keeps the bit set.
- R3: The IRQ enables sit at address 8 (events 16-23) and address 9 (events 24-31). Only positions set in IRQ_ROUTE (default 16'h3CFF) can be written, and the others read 0. irq_o is 1 when any of events 16-31 has both its status bit and its IRQ enable set. The sleep type has no effect on irq_o.
- R4: The SMI enables sit at addresses 10 and 11, with the same layout, masked by SMI_ROUTE (default 16'hFF0F). smi_o follows the same rule as irq_o, using these enables. The sleep type has no effect on smi_o.
- R5: The SCI enables sit at addresses 4 to 7, with the same layout as the status bits. sci_o is 1 when any status bit has its SCI enable set.
- R6: Address 12 holds the extra status bits: bit 0 power (event PWR_EV, default 0), bit 1 sleep (SLP_EV, default 1), bit 2 clock (RTC_EV, default 2). Each is set by its event and cleared by writing 1. Address 13 bits 0-2 hold the matching extra enables. sci_o is also 1 when any extra status bit has its extra enable set.
- R7: Configuration address 15 bits 0-2 switch on the extra pairs for power, sleep and clock. While a bit is 0, the extra status and enable bits for that event are held at 0, and writes to them have no effect.
- R8: The sleep type is address 14 bits 2:0. When it is 1 to 5 and configuration bit 3 (external-state select) is 0, a set extra power status bit raises sci_o regardless of its enable. This bypass does not apply for sleep types 0, 6 or 7.
- R9: Address 12 bit 7 is the wake flag. It is set in the cycle after sci_o is 1 while the sleep type is 1 to 5 and configuration bit 3 is 0. It is cleared by writing 1.
- R10: irq_o, smi_o and sci_o are registered. Each reflects the status and enables one clock after they change. reg_rdata shows the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in | input | 32 | Event inputs, one per status bit, high for each cycle the event is present |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq_o | output | 1 | General interrupt request level |
| smi_o | output | 1 | System-management interrupt level |
| sci_o | output | 1 | Power-management interrupt level |

## Verification
The bench drives single events into routable and non-routable positions of the upper banks. This separates the IRQ and SMI route masks from the plain set-and-enable rule. It also writes clears with zero data and in the same cycle as an event, which separates real write-one-to-clear from a plain overwrite. The power-button pair is tried with sleep type 0, 3 and 6, and with external select on and off. These cases show whether the bypass and the wake flag are limited to true sleep states. Switching the dual-control bits off while the pairs are set shows whether the pairs are held at zero or merely gated.

// File: rtl/pm_event_irq_hub.sv
module pm_event_irq_hub #(
  parameter int BANK_W = 8,
  parameter logic [15:0] IRQ_ROUTE = 16'h3CFF,
  parameter logic [15:0] SMI_ROUTE = 16'hFF0F,
  parameter int PWR_EV = 0,
  parameter int SLP_EV = 1,
  parameter int RTC_EV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4*BANK_W-1:0] ev_in,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [BANK_W-1:0] reg_wdata,
  output logic [BANK_W-1:0] reg_rdata,
  output logic              irq_o,
  output logic              smi_o,
  output logic              sci_o
);
  localparam int NEV = 4 * BANK_W;
  localparam int RW  = 2 * BANK_W;

  logic [NEV-1:0] sts, sci_en, sts_clr;
  logic [RW-1:0]  irq_en, smi_en;
  logic [2:0]     xsts, xen, slp_typ;
  logic [3:0]     cfg;
  logic           wak_sts;

  wire [2:0] dual_on  = cfg[2:0];
  wire       ext_sel  = cfg[3];
  wire       sleeping = (slp_typ != 3'd0) && (slp_typ <= 3'd5);
  wire       pm_wr    = reg_we && reg_addr == 4'd12;
  wire [2:0] xset     = {ev_in[RTC_EV], ev_in[SLP_EV], ev_in[PWR_EV]};
  wire [2:0] xclr     = pm_wr ? reg_wdata[2:0] : 3'b0;

  for (genvar b = 0; b < 4; b++) begin : g_bank
    assign sts_clr[b*BANK_W +: BANK_W] = (reg_we && reg_addr == 4'(b)) ? reg_wdata : '0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sci_en[b*BANK_W +: BANK_W] <= '0;
      else if (reg_we && reg_addr == 4'(4 + b)) sci_en[b*BANK_W +: BANK_W] <= reg_wdata;
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        irq_en[h*BANK_W +: BANK_W] <= '0;
        smi_en[h*BANK_W +: BANK_W] <= '0;
      end else begin
        if (reg_we && reg_addr == 4'(8 + h))
          irq_en[h*BANK_W +: BANK_W] <= reg_wdata & IRQ_ROUTE[h*BANK_W +: BANK_W];
        if (reg_we && reg_addr == 4'(10 + h))
          smi_en[h*BANK_W +: BANK_W] <= reg_wdata & SMI_ROUTE[h*BANK_W +: BANK_W];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sts     <= '0;
      xsts    <= '0;
      xen     <= '0;
      wak_sts <= 1'b0;
      slp_typ <= '0;
      cfg     <= '0;
      irq_o   <= 1'b0;
      smi_o   <= 1'b0;
      sci_o   <= 1'b0;
    end else begin
      sts     <= (sts & ~sts_clr) | ev_in;
      xsts    <= ((xsts & ~xclr) | xset) & dual_on;
      xen     <= ((reg_we && reg_addr == 4'd13) ? reg_wdata[2:0] : xen) & dual_on;
      wak_sts <= (wak_sts & ~(pm_wr & reg_wdata[BANK_W-1])) | (sci_o & sleeping & ~ext_sel);
      if (reg_we && reg_addr == 4'd14) slp_typ <= reg_wdata[2:0];
      if (reg_we && reg_addr == 4'd15) cfg <= reg_wdata[3:0];
      irq_o <= |(sts[NEV-1:RW] & irq_en);
      smi_o <= |(sts[NEV-1:RW] & smi_en);
      sci_o <= (|(sts & sci_en)) | (|(xsts & xen)) | (sleeping & ~ext_sel & xsts[0]);
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      4'd0, 4'd1, 4'd2, 4'd3: reg_rdata = sts[reg_addr[1:0]*BANK_W +: BANK_W];
      4'd4, 4'd5, 4'd6, 4'd7: reg_rdata = sci_en[reg_addr[1:0]*BANK_W +: BANK_W];
      4'd8, 4'd9:             reg_rdata = irq_en[reg_addr[0]*BANK_W +: BANK_W];
      4'd10, 4'd11:           reg_rdata = smi_en[reg_addr[0]*BANK_W +: BANK_W];
      4'd12: begin
        reg_rdata[2:0]        = xsts;
        reg_rdata[BANK_W-1]   = wak_sts;
      end
      4'd13:                  reg_rdata[2:0] = xen;
      4'd14:                  reg_rdata[2:0] = slp_typ;
      default:                reg_rdata[3:0] = cfg;
    endcase
  end
endmodule

// File: rtl/pm_event_irq_hub_chk.sv
module pm_event_irq_hub_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [31:0] ev_in,
  input logic [31:0] sts,
  input logic [31:0] sci_en,
  input logic [2:0]  xsts,
  input logic [2:0]  xen,
  input logic [3:0]  cfg,
  input logic [2:0]  slp_typ,
  input logic        sci_o,
  input logic        wak_sts
);
  wire asleep = (slp_typ >= 3'd1) && (slp_typ <= 3'd5) && !cfg[3];

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_in != 32'd0) |=> ((sts & $past(ev_in)) == $past(ev_in))); // R2
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ((sts & $past(sts)) == $past(sts))); // R2
  AST_SCI_FROM_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & sci_en) != 32'd0) |=> sci_o); // R5
  AST_PAIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[2:0] != 3'b111) |=> (((xsts | xen) & ~$past(cfg[2:0])) == 3'b000)); // R7
  AST_PWR_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && xsts[0]) |=> sci_o); // R8
  AST_WAKE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && sci_o) |=> wak_sts); // R9
endmodule

bind pm_event_irq_hub pm_event_irq_hub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .ev_in(ev_in), .sts(sts),
  .sci_en(sci_en), .xsts(xsts), .xen(xen), .cfg(cfg), .slp_typ(slp_typ),
  .sci_o(sci_o), .wak_sts(wak_sts)
);

// File: tb/test_pm_event_irq_hub.sv
module test_pm_event_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ev_in = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_o, smi_o, sci_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pm_event_irq_hub i_pm_event_irq_hub (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .smi_o(smi_o), .sci_o(sci_o)
  );

  // reference model: one byte per address
  logic [7:0] m [16];
  logic m_irq, m_smi, m_sci;
  localparam logic [15:0] IRQ_OK = 16'h3CFF;
  localparam logic [15:0] SMI_OK = 16'hFF0F;
  int spc [3] = '{0, 1, 2};

  always @(posedge clk or negedge rst_n) begin : model
    logic [7:0] o [16];
    bit sl, ext, ni, ns, nc;
    if (!rst_n) begin
      for (int a = 0; a < 16; a++) m[a] = 8'h00;
      m_irq = 0; m_smi = 0; m_sci = 0;
    end else begin
      for (int a = 0; a < 16; a++) o[a] = m[a];
      sl  = (o[14] >= 1) && (o[14] <= 5);
      ext = o[15][3];
      ni = 0; ns = 0; nc = 0;
      for (int k = 0; k < 16; k++) begin
        if (o[2 + k/8][k%8] && o[8 + k/8][k%8]) ni = 1;
        if (o[2 + k/8][k%8] && o[10 + k/8][k%8]) ns = 1;
      end
      for (int k = 0; k < 32; k++) if (o[k/8][k%8] && o[4 + k/8][k%8]) nc = 1;
      for (int j = 0; j < 3; j++) if (o[12][j] && o[13][j]) nc = 1;
      if (sl && !ext && o[12][0]) nc = 1;
      if (reg_we) begin
        case (reg_addr)
          0, 1, 2, 3, 12: m[reg_addr] = o[reg_addr] & ~reg_wdata;
          8:  m[8]  = reg_wdata & IRQ_OK[7:0];
          9:  m[9]  = reg_wdata & IRQ_OK[15:8];
          10: m[10] = reg_wdata & SMI_OK[7:0];
          11: m[11] = reg_wdata & SMI_OK[15:8];
          13, 14: m[reg_addr] = reg_wdata & 8'h07;
          15: m[15] = reg_wdata & 8'h0F;
          default: m[reg_addr] = reg_wdata;
        endcase
      end
      for (int k = 0; k < 32; k++) if (ev_in[k]) m[k/8][k%8] = 1'b1;
      for (int j = 0; j < 3; j++) if (ev_in[spc[j]]) m[12][j] = 1'b1;
      if (m_sci && sl && !ext) m[12][7] = 1'b1;
      for (int j = 0; j < 3; j++) if (!o[15][j]) begin m[12][j] = 1'b0; m[13][j] = 1'b0; end
      m_irq = ni; m_smi = ns; m_sci = nc;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 irq_o vs model", {7'b0, irq_o}, {7'b0, m_irq});
    chk("R4 smi_o vs model", {7'b0, smi_o}, {7'b0, m_smi});
    chk("R5 sci_o vs model", {7'b0, sci_o}, {7'b0, m_sci});
    chk("R1 reg_rdata vs model", reg_rdata, m[reg_addr]);
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_we = 0;
  endtask

  task automatic pulse(input int k);
    @(negedge clk); #1;
    ev_in = 32'd1 << k;
    @(negedge clk); #1;
    ev_in = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic look(input logic [3:0] a);
    @(negedge clk); #1;
    reg_addr = a;
    @(negedge clk);
  endtask

  task automatic clear_all();
    for (int a = 4; a < 14; a++) wr(4'(a), 8'h00);
    for (int a = 0; a < 4; a++) wr(4'(a), 8'hFF);
    wr(4'd12, 8'hFF);
    idle(3);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      look(4'(a));
      chk("R1 reset register", reg_rdata, 8'h00);
    end
    chk("R1 reset outputs", {5'b0, irq_o, smi_o, sci_o}, 8'h00);

    // R2 / R5 / R10 sticky status, SCI, latency
    wr(4'd4, 8'h08);
    #0 reg_addr = 4'd0;
    @(negedge clk); #1;
    ev_in = 32'h8;
    @(negedge clk);
    chk("R2 status set after event", reg_rdata, 8'h08);
    chk("R10 sci_o not yet raised", {7'b0, sci_o}, 8'h00);
    #1 ev_in = '0;
    @(negedge clk);
    chk("R10 sci_o one clock later", {7'b0, sci_o}, 8'h01);
    wr(4'd0, 8'h00);
    look(4'd0);
    chk("R2 write of zero keeps status", reg_rdata, 8'h08);
    @(negedge clk); #1;
    reg_we = 1; reg_addr = 4'd0; reg_wdata = 8'h08; ev_in = 32'h8;
    @(negedge clk); #1;
    reg_we = 0; ev_in = '0;
    look(4'd0);
    chk("R2 event wins over clear", reg_rdata, 8'h08);
    wr(4'd0, 8'h08);
    look(4'd0);
    chk("R2 write one clears", reg_rdata, 8'h00);
    idle(2);
    chk("R5 sci_o drops after clear", {7'b0, sci_o}, 8'h00);

    // R3 IRQ routing
    clear_all();
    wr(4'd8, 8'hFF); wr(4'd9, 8'hFF);
    look(4'd9);
    chk("R3 non-routable IRQ enables read 0", reg_rdata, 8'h3C);
    pulse(24);
    idle(2);
    chk("R3 non-routable event no IRQ", {7'b0, irq_o}, 8'h00);
    pulse(26);
    idle(2);
    chk("R3 routable event raises IRQ", {7'b0, irq_o}, 8'h01);
    wr(4'd14, 8'h03);
    idle(2);
    chk("R3 IRQ ignores sleep type", {7'b0, irq_o}, 8'h01);
    wr(4'd14, 8'h00);

    // R4 SMI routing
    clear_all();
    wr(4'd10, 8'hFF); wr(4'd11, 8'hFF);
    look(4'd10);
    chk("R4 non-routable SMI enables read 0", reg_rdata, 8'h0F);
    pulse(20);
    idle(2);
    chk("R4 non-routable event no SMI", {7'b0, smi_o}, 8'h00);
    pulse(29);
    idle(2);
    chk("R4 routable event raises SMI", {7'b0, smi_o}, 8'h01);
    wr(4'd14, 8'h05);
    idle(2);
    chk("R4 SMI ignores sleep type", {7'b0, smi_o}, 8'h01);
    wr(4'd14, 8'h00);

    // R6 / R7 dual pairs
    clear_all();
    wr(4'd13, 8'h07);
    look(4'd13);
    chk("R7 extra enables held while off", reg_rdata, 8'h00);
    pulse(1);
    look(4'd12);
    chk("R7 extra status held while off", reg_rdata, 8'h00);
    wr(4'd15, 8'h07);
    wr(4'd13, 8'h02);
    pulse(1);
    idle(2);
    look(4'd12);
    chk("R6 extra sleep status set", reg_rdata, 8'h02);
    chk("R6 extra pair raises SCI", {7'b0, sci_o}, 8'h01);
    wr(4'd15, 8'h00);
    look(4'd12);
    chk("R7 pair cleared by config", reg_rdata, 8'h00);
    look(4'd13);
    chk("R7 enables cleared by config", reg_rdata, 8'h00);

    // R8 / R9 power bypass and wake flag
    clear_all();
    wr(4'd15, 8'h01);
    pulse(0);
    idle(3);
    chk("R8 no bypass in awake state", {7'b0, sci_o}, 8'h00);
    wr(4'd14, 8'h06);
    idle(3);
    chk("R8 no bypass for type 6", {7'b0, sci_o}, 8'h00);
    wr(4'd14, 8'h03);
    idle(3);
    chk("R8 bypass in sleep", {7'b0, sci_o}, 8'h01);
    look(4'd12);
    chk("R9 wake flag set", reg_rdata, 8'h81);
    wr(4'd14, 8'h00);
    idle(2);
    wr(4'd12, 8'h80);
    look(4'd12);
    chk("R9 wake flag cleared", reg_rdata, 8'h01);
    wr(4'd15, 8'h09);
    wr(4'd14, 8'h03);
    idle(3);
    chk("R8 no bypass with external select", {7'b0, sci_o}, 8'h00);
    look(4'd12);
    chk("R9 no wake with external select", reg_rdata, 8'h01);

    idle(4);
    finish_run();
  end
endmodule